// File: doc/BRIEF.md
# Four-Axis Joystick Position Counter

This block measures the position of up to four joystick axes. Each axis is presented as a comparator input that stays high for a time proportional to the stick position once a measurement has begun. A write of any value to the trigger port clears the counters and starts a measurement. Each enabled axis then counts prescaled clock ticks for as long as its comparator is high. When the comparator drops, the count is captured in that axis's result latch.

Software configures the block through two byte-wide registers. The axis register enables each axis, selects which latch is presented on the 16-bit result output, turns on free-running remeasurement, and shows a read-only ready flag. The hardware register sets the tick rate and enables a one-cycle completion interrupt. The result output is registered and follows the selected latch with one cycle of delay.

Top module: `gameport_axis_latch`

## Requirements
- R1: After a synchronous reset, both register readbacks, the result output and the interrupt are all zero.
- R2: A write to address 0 stores data bits 6:0 in the axis register: bits 3:0 enable axes 0–3, bits 5:4 select the axis to read, and bit 6 turns on free-running mode. Readback bit 7 is the ready flag, and writes to bit 7 are ignored.
- R3: A write to address 2 stores data bits 2:0 in the hardware register: bit 0 enables the interrupt and bits 2:1 select the rate. Readback bits 7:3 are always zero.
- R4: A write to address 1, with any data, restarts every enabled axis counter from zero. On each tick where its comparator is high, the counter adds one. On the first tick where the comparator is low, the axis finishes and its count is latched.
- R5: The rate code gives one tick every D cycles: 00 gives D=1, 10 gives D=2, 01 gives D=20 and 11 gives D=200. The first tick falls D cycles after the trigger edge.
- R6: The 16-bit result output shows the latch of the axis named by the select field, one clock after the select field or the latch changes.
- R7: A counter that reaches 0xFFFF finishes on its next tick with 0xFFFF latched, whatever the comparator level.
- R8: The ready flag rises one cycle after the last enabled axis finishes, or one cycle after the trigger if no axis is enabled. A trigger write clears it.
- R9: The interrupt is a single-cycle pulse in the same cycle that a measurement completes. It occurs only when interrupt enable is set and at least one axis is enabled.
- R10: The latch of a disabled axis keeps its previous value through a measurement.
- R11: In free-running mode, each completion immediately starts a new measurement, so latches refresh and interrupts repeat. Ready stays set.
- R12: If a trigger write and a completion fall in the same cycle, the interrupt still pulses, but ready stays cleared and a new measurement begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 axis register, 1 trigger, 2 hardware register |
| wr_data | input | 8 | Write data |
| comp | input | 4 | Comparator level per axis, high while timing |
| axis_cfg_rd | output | 8 | Axis register readback, bit 7 is ready |
| hw_cfg_rd | output | 8 | Hardware register readback |
| axis_value | output | 16 | Latched count of the selected axis |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A software trigger and a measurement completion can fall in the same clock cycle. The bench provokes this collision at full rate with every comparator low: the first trigger completes exactly two edges later, and a second trigger write is placed on that edge. It then checks that the interrupt pulses on that edge, that ready stays low for the following cycle, and that ready rises two edges later when the restarted measurement finishes.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  typedef enum logic [1:0] {
    REG_AXCFG = 2'd0,
    REG_TRIG  = 2'd1,
    REG_HWCFG = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned DIV_FULL = 1;
  localparam int unsigned DIV_HALF = 2;
  localparam int unsigned DIV_SLOW = 20;
  localparam int unsigned DIV_SLOWEST = 200;

  function automatic int unsigned rate_div(input logic [1:0] code);
    case (code)
      2'b00:   return DIV_FULL;
      2'b10:   return DIV_HALF;
      2'b01:   return DIV_SLOW;
      default: return DIV_SLOWEST;
    endcase
  endfunction
endpackage

// File: rtl/gpl_prescaler.sv
module gpl_prescaler
  import gpl_pkg::*;
#(
  parameter int unsigned PW = $clog2(DIV_SLOWEST) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;

  assign last = PW'(rate_div(code)) - ONE;
  assign tick = run && !restart && (pre_q >= last);

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run) begin
      if (pre_q >= last) pre_q <= '0;
      else               pre_q <= pre_q + ONE;
    end
  end

  // R5: phase counter never runs past the slowest divisor
  p_pre_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pre_q < PW'(DIV_SLOWEST));
endmodule

// File: rtl/gpl_axis_counter.sv
module gpl_axis_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          enable,
  input  logic          tick,
  input  logic          comp,
  output logic          busy,
  output logic [CW-1:0] latch
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      latch <= '0;
    end else if (start) begin
      cnt_q <= '0;
      busy  <= enable;
    end else if (busy && tick) begin
      if (!comp || cnt_q == MAXV) begin
        busy  <= 1'b0;
        latch <= cnt_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: while an axis is timing, its count never goes backwards
  p_cnt_mono_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt_q >= $past(cnt_q)));

  // R7: a saturated count finishes on the next tick holding full scale
  p_sat_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && tick && cnt_q == MAXV) |=> (!busy && latch == MAXV));

  // R10: a disabled axis does not alter its latch
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(start && enable)) |=> $stable(latch));
endmodule

// File: rtl/gameport_axis_latch.sv
module gameport_axis_latch
  import gpl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       comp,
  output logic [7:0]       axis_cfg_rd,
  output logic [7:0]       hw_cfg_rd,
  output logic [CNT_W-1:0] axis_value,
  output logic             irq
);
  localparam int unsigned NAX = 4;

  logic [6:0] axcfg_q;
  logic [2:0] hwcfg_q;
  logic       ready_q;
  logic       meas_q;
  logic       irq_q;
  logic [CNT_W-1:0] val_q;

  logic [NAX-1:0]            busy;
  logic [NAX-1:0][CNT_W-1:0] lat;
  logic wr_trig, done_evt, start, tick;

  assign wr_trig  = wr_en && (wr_addr == REG_TRIG);
  assign done_evt = meas_q && (busy == '0);
  assign start    = wr_trig || (done_evt && axcfg_q[6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      axcfg_q <= '0;
      hwcfg_q <= '0;
      ready_q <= 1'b0;
      meas_q  <= 1'b0;
      irq_q   <= 1'b0;
      val_q   <= '0;
    end else begin
      if (wr_en && wr_addr == REG_AXCFG) axcfg_q <= wr_data[6:0];
      if (wr_en && wr_addr == REG_HWCFG) hwcfg_q <= wr_data[2:0];
      if (wr_trig) begin
        meas_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (done_evt) begin
        meas_q  <= axcfg_q[6];
        ready_q <= 1'b1;
      end
      irq_q <= done_evt && hwcfg_q[0] && (axcfg_q[3:0] != '0);
      val_q <= lat[axcfg_q[5:4]];
    end
  end

  gpl_prescaler u_pre (
    .clk(clk), .rst(rst), .restart(start), .run(meas_q),
    .code(hwcfg_q[2:1]), .tick(tick)
  );

  for (genvar i = 0; i < NAX; i++) begin : g_axis
    gpl_axis_counter #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .start(start), .enable(axcfg_q[i]),
      .tick(tick), .comp(comp[i]), .busy(busy[i]), .latch(lat[i])
    );
  end

  assign axis_cfg_rd = {ready_q, axcfg_q};
  assign hw_cfg_rd   = {5'b0, hwcfg_q};
  assign axis_value  = val_q;
  assign irq         = irq_q;

  // R8: a trigger write leaves ready low on the next cycle
  p_ready_clear_r8: assert property (@(posedge clk) disable iff (rst)
    wr_trig |=> !ready_q);

  // R9: interrupt is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R9: interrupt only with enable set in the cycle before
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(hwcfg_q[0]));

  // R12: an interrupt is always followed by ready or a live measurement
  p_irq_state_r12: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ready_q || meas_q));
endmodule

// File: tb/gameport_axis_latch_test.sv
module gameport_axis_latch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [3:0]  comp = 4'd0;
  logic [7:0]  axis_cfg_rd, hw_cfg_rd;
  logic [15:0] axis_value;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int exp_lat [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  gameport_axis_latch uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .comp(comp), .axis_cfg_rd(axis_cfg_rd), .hw_cfg_rd(hw_cfg_rd),
    .axis_value(axis_value), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int div_of(input logic [1:0] code);
    case (code)
      2'b00: return 1;
      2'b10: return 2;
      2'b01: return 20;
      default: return 200;
    endcase
  endfunction

  // full measurement with expected values from R4/R5/R7/R8/R9
  task automatic measure(input logic [1:0] code, input bit ien, input logic [3:0] en,
                         input int m [4], input string tag);
    int d, fin, cnt, rdy_e, irq_n, irq_e;
    d = div_of(code);
    fin = 0;
    wr(2'd2, {5'b0, code, ien});
    wr(2'd0, {4'b0, en});
    for (int i = 0; i < 4; i++) begin
      if (en[i]) begin
        cnt = (m[i] / d > 65535) ? 65535 : m[i] / d;
        exp_lat[i] = cnt;
        if ((cnt + 1) * d > fin) fin = (cnt + 1) * d;
      end
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h5A;
    rdy_e = -1; irq_n = 0; irq_e = -1;
    for (int e = 0; e < 140000; e++) begin
      @(negedge clk);
      if (e == 0) wr_en = 1'b0;
      for (int i = 0; i < 4; i++) comp[i] = (e + 1 <= m[i]);
      if (irq) begin irq_n++; irq_e = e; end
      if (axis_cfg_rd[7]) begin rdy_e = e; break; end
    end
    check(rdy_e == fin + 1, {tag, " R8 ready edge"}, rdy_e, fin + 1);
    check(irq_n == ((ien && en != 0) ? 1 : 0), {tag, " R9 irq count"}, irq_n,
          (ien && en != 0) ? 1 : 0);
    if (irq_n == 1) check(irq_e == fin + 1, {tag, " R9 irq edge"}, irq_e, fin + 1);
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, {2'b0, s[1:0], en});
      @(negedge clk);
      check(int'(axis_value) == exp_lat[s], {tag, " R4 R6 R10 axis value"},
            int'(axis_value), exp_lat[s]);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int m [4];
    int d, pulses;
    logic [1:0] codes [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(axis_cfg_rd == 8'h00, "R1 axis reg", axis_cfg_rd, 0);
    check(hw_cfg_rd == 8'h00, "R1 hw reg", hw_cfg_rd, 0);
    check(axis_value == 16'h0, "R1 value", axis_value, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    // R2: bit 7 write ignored
    wr(2'd0, 8'hFF);
    check(axis_cfg_rd == 8'h7F, "R2 axis readback", axis_cfg_rd, 8'h7F);
    wr(2'd0, 8'h00);
    // R3
    wr(2'd2, 8'hFF);
    check(hw_cfg_rd == 8'h07, "R3 hw readback", hw_cfg_rd, 8'h07);
    wr(2'd2, 8'hA4);
    check(hw_cfg_rd == 8'h04, "R3 hw readback", hw_cfg_rd, 8'h04);

    // R4/R5 sweep over all rates and several release points
    foreach (codes[c]) begin
      d = div_of(codes[c]);
      m = '{0, d - 1, 2 * d, 3 * d + 1};
      measure(codes[c], 1'b1, 4'hF, m, "R5 sweep a");
      m = '{d + 3, 1, 4 * d - 1, d};
      measure(codes[c], 1'b1, 4'hF, m, "R5 sweep b");
    end
    // R10: only axis 0 enabled, others keep old values; R9 irq off
    m = '{7, 99, 99, 99};
    measure(2'b00, 1'b0, 4'h1, m, "R10 partial");
    // R8: no axes enabled, ready one cycle after trigger, no irq
    m = '{0, 0, 0, 0};
    measure(2'b00, 1'b1, 4'h0, m, "R8 empty");
    // R7: saturation
    m = '{70000, 0, 0, 0};
    measure(2'b00, 1'b1, 4'h1, m, "R7 saturate");

    // R12: trigger on the completion edge
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01);
    comp = 4'h0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1;   // E0
    @(negedge clk); wr_en = 1'b0;                   // after E0
    @(negedge clk); wr_en = 1'b1;                   // after E1, write hits E2
    @(negedge clk); wr_en = 1'b0;                   // after E2
    check(irq == 1'b1, "R12 irq on collision", irq, 1);
    check(axis_cfg_rd[7] == 1'b0, "R12 ready held low", axis_cfg_rd[7], 0);
    @(negedge clk);                                 // after E3
    check(axis_cfg_rd[7] == 1'b0, "R12 ready low during rerun", axis_cfg_rd[7], 0);
    @(negedge clk);                                 // after E4
    check(axis_cfg_rd[7] == 1'b1, "R12 ready after rerun", axis_cfg_rd[7], 1);

    // R11: free-running mode repeats interrupts
    wr(2'd0, 8'h43);
    comp = 4'h0;
    wr(2'd1, 8'h00);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check(pulses >= 5, "R11 repeated irq", pulses, 5);
    check(axis_cfg_rd[7] == 1'b1, "R11 ready stays set", axis_cfg_rd[7], 1);
    wr(2'd0, 8'h03);
    repeat (5) @(negedge clk);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check(pulses == 0, "R11 stops when cleared", pulses, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule